// File: doc/BRIEF.md
# Fine Interval Combiner with Shared Tap Capture

This block sharpens a gated period measurement by resolving the fractional parts of the window at both of its edges. A separate delay line receives the start edge. A stop edge freezes the line's tap states. Those frozen taps reach this block as a vector together with a one-cycle strobe. The block turns each frozen vector into a tap count. Bubbles are cleaned up by a three-tap majority vote.

There is only one capture path. A two-state sequencer sends the first capture to the start-offset slot (n1) and the second capture to the end-offset slot (n2). After every capture the block re-arms the latch.

A coarse count of reference pulses (n0) comes in on its own port. When n0, n1 and n2 have all been collected, the block produces one signed fixed-point time value in units of one tap delay: n0·(t0/t1) + n1 − n2. It pulses a valid flag with that value. If a captured vector is all ones, the delay line overran. In that case the block raises a range error and gives no count.

Top module: `tap_interp_combiner`

## Requirements
- R1: After reset, valid_o, range_err_o and rearm_o are low and result_o is zero.
- R2: Bit 0 of taps_i is the tap nearest the launch point. The tap count of a capture is the number of consecutive ones starting at bit 0, taken after correction. For a clean thermometer pattern with k ones, the count is k.
- R3: Correction replaces each tap bit with the majority of itself and its two neighbours. The neighbour below bit 0 counts as 1 and the neighbour above the top bit counts as 0. So a single isolated zero inside the ones, or a single isolated one above them, does not change the count.
- R4: The first non-overrun strobe of a measurement fills n1 and the second fills n2. Captures after that alternate in the same order.
- R5: rearm_o is high for exactly the one cycle that follows each cycle in which tap_strobe_i is high.
- R6: The result is n0·RATIO_Q + (n1 − n2)·2^FB, in two's complement over RW bits. It is fixed point with FB fraction bits in tap units. With the defaults, RATIO_Q is 5953, which is 100/4.3 scaled by 256.
- R7: valid_o pulses for one cycle, one cycle after the last of n0, n1 and n2 has been registered. n0 may arrive before, between or after the captures. Collection then starts over, and result_o holds its value until the next pulse.
- R8: If taps_i is all ones when strobed, range_err_o pulses on the next cycle and no count is stored. Any partial n0 or n1 is discarded, the sequencer returns to the n1 slot, and valid_o stays low in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| taps_i | input | TAPS | Frozen delay-line tap states |
| tap_strobe_i | input | 1 | One-cycle mark: taps_i holds a new capture |
| coarse_i | input | CW | Coarse reference pulse count n0 |
| coarse_valid_i | input | 1 | coarse_i is valid this cycle |
| rearm_o | output | 1 | Re-arm pulse for the tap latch |
| range_err_o | output | 1 | Overrun pulse (all taps set) |
| result_o | output | RW | Signed fixed-point interval in tap units |
| valid_o | output | 1 | result_o updated this cycle |

## Verification
The assertions assume the following about the inputs:
- tap_strobe_i lasts one cycle per capture.
- An overrun strobe never coincides with a coarse count or with a completing measurement.

The stimulus respects these limits by driving each strobe and each coarse count as a single-cycle pulse, each in its own cycle and on the falling edge. It presents at most one capture per measurement as an overrun, and only between complete measurements.

// File: rtl/tap_interp_combiner.sv
module tap_interp_combiner #(
  parameter int TAPS    = 32,
  parameter int CW      = 16,
  parameter int FB      = 8,
  parameter int RQW     = 16,
  parameter int RATIO_Q = 5953,
  localparam int CNTW   = $clog2(TAPS + 1),
  localparam int RW     = CW + RQW + 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [TAPS-1:0]      taps_i,
  input  logic                 tap_strobe_i,
  input  logic [CW-1:0]        coarse_i,
  input  logic                 coarse_valid_i,
  output logic                 rearm_o,
  output logic                 range_err_o,
  output logic signed [RW-1:0] result_o,
  output logic                 valid_o
);

  logic [TAPS+1:0] ext;
  logic [TAPS-1:0] fixed;
  logic [CNTW-1:0] cnt, n1_q, n2_q;
  logic [CW-1:0]   n0_q;
  logic            have_n0, have_n1, have_n2, second;
  logic            overrun, have_all;

  assign ext      = {1'b0, taps_i, 1'b1};
  assign overrun  = &taps_i;
  assign have_all = have_n0 & have_n1 & have_n2;

  always_comb begin
    for (int i = 0; i < TAPS; i++)
      fixed[i] = (ext[i] & ext[i+1]) | (ext[i] & ext[i+2]) | (ext[i+1] & ext[i+2]);
    cnt = CNTW'(TAPS);
    for (int i = TAPS - 1; i >= 0; i--)
      if (!fixed[i]) cnt = CNTW'(i);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      n0_q <= '0; n1_q <= '0; n2_q <= '0;
      have_n0 <= 1'b0; have_n1 <= 1'b0; have_n2 <= 1'b0; second <= 1'b0;
      rearm_o <= 1'b0; range_err_o <= 1'b0; valid_o <= 1'b0; result_o <= '0;
    end else begin
      rearm_o     <= tap_strobe_i;
      valid_o     <= 1'b0;
      range_err_o <= 1'b0;
      if (have_all) begin
        result_o <= RW'(n0_q) * RW'(RATIO_Q) + ((RW'(n1_q) - RW'(n2_q)) << FB);
        valid_o  <= 1'b1;
        have_n0  <= 1'b0; have_n1 <= 1'b0; have_n2 <= 1'b0;
      end
      if (coarse_valid_i) begin
        n0_q    <= coarse_i;
        have_n0 <= 1'b1;
      end
      if (tap_strobe_i) begin
        if (overrun) begin
          range_err_o <= 1'b1;
          valid_o     <= 1'b0;
          second      <= 1'b0;
          have_n0 <= 1'b0; have_n1 <= 1'b0; have_n2 <= 1'b0;
        end else if (!second) begin
          n1_q <= cnt; have_n1 <= 1'b1; second <= 1'b1;
        end else begin
          n2_q <= cnt; have_n2 <= 1'b1; second <= 1'b0;
        end
      end
    end
  end

  AST_REARM_AFTER_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    tap_strobe_i |=> rearm_o); // R5
  AST_OVERRUN_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
    (tap_strobe_i && taps_i == '1) |=> range_err_o); // R8
  AST_NO_VALID_WITH_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    range_err_o |-> !valid_o); // R8
  AST_VALID_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |=> !valid_o); // R7
  AST_RESULT_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_o |-> $stable(result_o)); // R7

endmodule

// File: tb/tap_interp_combiner_test.sv
module tap_interp_combiner_test;
  localparam int TAPS = 32, CW = 16, RW = 34;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [TAPS-1:0] taps = '0;
  logic strobe = 1'b0, cv = 1'b0;
  logic [CW-1:0] coarse = '0;
  logic rearm, rerr, valid;
  logic signed [RW-1:0] result;

  int checks = 0, fails = 0, valids_seen = 0, valids_expected = 0;
  bit done = 0;
  longint expq[$];

  tap_interp_combiner uut (
    .clk(clk), .rst_n(rst_n), .taps_i(taps), .tap_strobe_i(strobe),
    .coarse_i(coarse), .coarse_valid_i(cv), .rearm_o(rearm),
    .range_err_o(rerr), .result_o(result), .valid_o(valid));

  always #5 clk = ~clk;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [TAPS-1:0] thermo(input int n);
    thermo = (n >= TAPS) ? '1 : ((TAPS'(1) << n) - TAPS'(1));
  endfunction

  function automatic longint model(input int n0, input int n1, input int n2);
    model = longint'(n0) * 5953 + longint'(n1 - n2) * 256;
  endfunction

  always @(negedge clk) if (rst_n && valid) begin
    valids_seen++;
    if (expq.size() == 0) chk(0, "R7 unexpected valid", 1, 0);
    else begin
      longint e;
      logic signed [RW-1:0] es;
      e = expq.pop_front();
      es = e[RW-1:0];
      chk(result == es, "R6 result", result, e);
    end
  end

  task automatic send_coarse(input int n);
    @(negedge clk); cv = 1; coarse = CW'(n);
    @(negedge clk); cv = 0;
  endtask

  task automatic send_strobe(input logic [TAPS-1:0] p, input bit expect_err);
    @(negedge clk); taps = p; strobe = 1;
    @(negedge clk); strobe = 0;
    chk(rearm == 1'b1, "R5 rearm", rearm, 1);
    chk(rerr == expect_err, "R8 range error", rerr, expect_err);
    if (expect_err) chk(valid == 1'b0, "R8 no valid on error", valid, 0);
  endtask

  task automatic measure(input int n0, input logic [TAPS-1:0] p1, input int c1,
                         input logic [TAPS-1:0] p2, input int c2, input int order);
    expq.push_back(model(n0, c1, c2));
    valids_expected++;
    if (order == 0) send_coarse(n0);
    send_strobe(p1, 0);
    if (order == 1) send_coarse(n0);
    send_strobe(p2, 0);
    if (order == 2) send_coarse(n0);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(valid == 0, "R1 valid", valid, 0);
    chk(rerr == 0, "R1 range_err", rerr, 0);
    chk(rearm == 0, "R1 rearm", rearm, 0);
    chk(result == 0, "R1 result", result, 0);
    rst_n = 1;
    @(negedge clk);
    // R2 clean thermometer, R4 order, coarse first
    measure(1000, thermo(12), 12, thermo(3), 3, 0);
    // R4 n1<n2 gives negative fraction part, coarse in middle
    measure(7, thermo(2), 2, thermo(20), 20, 1);
    // R2 zero and near-full counts, coarse last
    measure(0, thermo(0), 0, thermo(31), 31, 2);
    // R3 bubble inside ones, isolated one above
    measure(250, thermo(10) & ~(TAPS'(1) << 4), 10, thermo(6) | (TAPS'(1) << 8), 6, 0);
    // R3 bubble at bit 0
    measure(65535, thermo(5) & ~TAPS'(1), 5, thermo(1), 1, 1);
    // R8 overrun after first capture discards partial data
    send_coarse(99);
    send_strobe(thermo(4), 0);
    send_strobe('1, 1);
    repeat (3) @(negedge clk);
    chk(valids_seen == valids_expected, "R8 partial discarded", valids_seen, valids_expected);
    // R4 after error the next capture goes to n1 again
    measure(3, thermo(9), 9, thermo(8), 8, 2);
    chk(valids_seen == valids_expected, "R7 valid count", valids_seen, valids_expected);
    chk(expq.size() == 0, "R7 queue drained", expq.size(), 0);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule